// File: doc/BRIEF.md
# Serial Engine Run/Pause/Reset State Controller

This block keeps the operating mode of a serial engine (reset, run or pause) and presents it, together with a few status bits, in one 8-bit state word. A write to the mode field is taken only while the word's ready bit is high. An accepted change then takes a fixed number of clock cycles. During that time the ready bit is low and the old mode is still shown. When the new mode takes effect, the ready bit returns high in the same cycle.

The controller checks every mode request. A move into pause is only allowed from run. Such a move, or the unused code, is refused: the mode stays as it was and a sticky error bit is set. A soft-reset pulse puts the engine back into reset at once. It aborts any pending change, reloads the engine's operational flag word and serial status word with their reset patterns, and pulses a FIFO flush strobe. A registered copy of the serial core's master-ready signal is shown in the same word.

State word layout: bits [1:0] mode (reset = 0, run = 1, pause = 3, code 2 unused), bit 2 ready, bit 3 zero, bit 4 master ready, bit 5 sticky error, bits [7:6] zero.

Top module: `engine_state_ctrl`

## Requirements
- R1: After reset, state_o is 8'h04 (mode reset, ready set, no error, master ready clear), op_flags_o is 12'hFF0, serial_stat_o is 24'hFFFFFC and fifo_flush_o is 0.
- R2: A mode write taken while ready is set and legal clears ready from the next cycle for exactly XFER_CYCLES cycles. During that time bits [1:0] keep the old mode. In the cycle ready returns, bits [1:0] show the requested mode.
- R3: A mode write while ready is clear is ignored: it neither changes the outcome of the pending change nor sets the error bit.
- R4: Requests for reset (0) and run (1) are legal from any mode. A request for pause (3) is legal only when the current mode is run (1).
- R5: An illegal request (pause from a mode other than run, or code 2) leaves the mode unchanged and ready set, and sets bit 5 from the next cycle. Bit 5 then stays set until a soft reset.
- R6: soft_reset_i forces, from the next cycle, mode reset with ready set and bit 5 clear. It aborts any pending change and takes priority over a mode write in the same cycle.
- R7: fifo_flush_o is high in exactly the cycle after soft_reset_i is sampled high, and low otherwise.
- R8: Bit 4 of state_o equals core_ready_i as sampled at the previous clock edge.
- R9: op_flags_o and serial_stat_o collect set-pulses on op_set_i and stat_set_i as sticky bits. A soft reset reloads 12'hFF0 and 24'hFFFFFC and wins over set-pulses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we_i | input | 1 | Write strobe for the mode field |
| mode_req_i | input | 2 | Requested mode code |
| soft_reset_i | input | 1 | Soft-reset pulse |
| core_ready_i | input | 1 | Master-ready indication from the serial core |
| op_set_i | input | 12 | Set-pulses for the operational flag word |
| stat_set_i | input | 24 | Set-pulses for the serial status word |
| state_o | output | 8 | State word: mode, ready, master ready, error |
| op_flags_o | output | 12 | Operational flag word |
| serial_stat_o | output | 24 | Serial status word |
| fifo_flush_o | output | 1 | One-cycle FIFO flush strobe after soft reset |

## Verification
The bench builds the block with XFER_CYCLES set to 3. A short window like this lets one test reach several stray writes during a pending change, a soft reset in its middle cycle, and the exact cycle of completion. The flag and status words keep their default widths and reset patterns, so the reload values are checked as they would appear in use.

// File: rtl/esc_pkg.sv
package esc_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_ACTIVE = 2'd1,
        ENG_RSVD   = 2'd2,
        ENG_HOLD   = 2'd3
    } eng_mode_e;

    // Packed view of the 8-bit state word, MSB first.
    typedef struct packed {
        logic [1:0] spare;
        logic       fault;
        logic       mast_rdy;
        logic       zero3;
        logic       ready;
        eng_mode_e  mode;
    } state_word_t;

    localparam int MODE_W = 2;
    localparam int WORD_W = 8;

    // Legal-move rule: idle and active can always be requested;
    // hold only from active; the spare code never.
    function automatic logic mode_change_ok(eng_mode_e cur, eng_mode_e nxt);
        logic ok;
        case (nxt)
            ENG_IDLE:   ok = 1'b1;
            ENG_ACTIVE: ok = 1'b1;
            ENG_HOLD:   ok = (cur == ENG_ACTIVE);
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic state_word_t pack_word(eng_mode_e m, logic rdy,
                                              logic mr, logic flt);
        state_word_t w;
        w.spare    = '0;
        w.fault    = flt;
        w.mast_rdy = mr;
        w.zero3    = 1'b0;
        w.ready    = rdy;
        w.mode     = m;
        return w;
    endfunction

endpackage

// File: rtl/esc_transition_seq.sv
module esc_transition_seq
    import esc_pkg::*;
#(
    parameter int XFER_CYCLES = 4,
    localparam int CNT_W = $clog2(XFER_CYCLES + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        soft_rst,
    input  logic        req_we,
    input  eng_mode_e   req_mode,
    output eng_mode_e   cur_mode,
    output logic        ready,
    output logic        fault
);

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(XFER_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic [CNT_W-1:0] wait_cnt;
    eng_mode_e        pend_mode;
    logic             busy;
    logic             take;

    assign busy  = (wait_cnt != '0);
    assign ready = !busy;
    assign take  = req_we && !busy;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            cur_mode  <= ENG_IDLE;
            pend_mode <= ENG_IDLE;
            wait_cnt  <= '0;
            fault     <= 1'b0;
        end else if (busy) begin
            wait_cnt <= wait_cnt - LAST;
            if (wait_cnt == LAST) begin
                cur_mode <= pend_mode;
            end
        end else if (take) begin
            if (mode_change_ok(cur_mode, req_mode)) begin
                pend_mode <= req_mode;
                wait_cnt  <= LOAD;
            end else begin
                fault <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/esc_sticky_bank.sv
module esc_sticky_bank #(
    parameter int          WIDTH = 12,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [WIDTH-1:0] set_pulse,
    output logic [WIDTH-1:0] value
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || reload) begin
                value[b] <= INIT[b];
            end else if (set_pulse[b]) begin
                value[b] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/engine_state_ctrl.sv
module engine_state_ctrl
    import esc_pkg::*;
#(
    parameter int               XFER_CYCLES = 4,
    parameter int               OP_W        = 12,
    parameter logic [OP_W-1:0]  OP_INIT     = 12'hFF0,
    parameter int               STAT_W      = 24,
    parameter logic [STAT_W-1:0] STAT_INIT  = 24'hFFFFFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we_i,
    input  logic [1:0]        mode_req_i,
    input  logic              soft_reset_i,
    input  logic              core_ready_i,
    input  logic [OP_W-1:0]   op_set_i,
    input  logic [STAT_W-1:0] stat_set_i,
    output logic [7:0]        state_o,
    output logic [OP_W-1:0]   op_flags_o,
    output logic [STAT_W-1:0] serial_stat_o,
    output logic              fifo_flush_o
);

    eng_mode_e   cur_mode;
    logic        seq_ready;
    logic        seq_fault;
    logic        mast_q;
    logic        flush_q;
    state_word_t word;

    esc_transition_seq #(
        .XFER_CYCLES (XFER_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_reset_i),
        .req_we   (mode_we_i),
        .req_mode (eng_mode_e'(mode_req_i)),
        .cur_mode (cur_mode),
        .ready    (seq_ready),
        .fault    (seq_fault)
    );

    esc_sticky_bank #(
        .WIDTH (OP_W),
        .INIT  (OP_INIT)
    ) u_op_bank (
        .clk       (clk),
        .rst       (rst),
        .reload    (soft_reset_i),
        .set_pulse (op_set_i),
        .value     (op_flags_o)
    );

    esc_sticky_bank #(
        .WIDTH (STAT_W),
        .INIT  (STAT_INIT)
    ) u_stat_bank (
        .clk       (clk),
        .rst       (rst),
        .reload    (soft_reset_i),
        .set_pulse (stat_set_i),
        .value     (serial_stat_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mast_q  <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            mast_q  <= core_ready_i;
            flush_q <= soft_reset_i;
        end
    end

    assign word         = pack_word(cur_mode, seq_ready, mast_q, seq_fault);
    assign state_o      = word;
    assign fifo_flush_o = flush_q;

endmodule

// File: rtl/engine_state_ctrl_checker.sv
module engine_state_ctrl_checker (
    input logic       clk,
    input logic       rst,
    input logic       mode_we_i,
    input logic [1:0] mode_req_i,
    input logic       soft_reset_i,
    input logic       core_ready_i,
    input logic [7:0] state_o,
    input logic       fifo_flush_o
);

    logic [1:0] mode_f;
    logic       rdy_f;
    logic       err_f;
    logic       mr_f;

    assign mode_f = state_o[1:0];
    assign rdy_f  = state_o[2];
    assign mr_f   = state_o[4];
    assign err_f  = state_o[5];

    // Ready can only drop after a write seen while ready.
    assert_ready_drop_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_f) |-> ($past(mode_we_i) && $past(rdy_f)));

    // Idle cycles while ready keep the mode field steady.
    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (rdy_f && !mode_we_i && !soft_reset_i) |=> $stable(mode_f));

    // Pause from a mode other than run is refused and flagged.
    assert_pause_refused_R4: assert property (@(posedge clk) disable iff (rst)
        (rdy_f && mode_we_i && mode_req_i == 2'd3 && mode_f != 2'd1 && !soft_reset_i)
        |=> (err_f && rdy_f && $stable(mode_f)));

    // Error bit stays set until a soft reset.
    assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (err_f && !soft_reset_i) |=> err_f);

    // Soft reset returns to reset mode, ready, no error.
    assert_soft_reset_R6: assert property (@(posedge clk) disable iff (rst)
        soft_reset_i |=> (mode_f == 2'd0 && rdy_f && !err_f));

    // Flush strobe follows soft reset by one cycle.
    assert_flush_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (fifo_flush_o == $past(soft_reset_i)));

    // Master-ready bit is a one-cycle delayed copy.
    assert_master_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (mr_f == $past(core_ready_i)));

    // Unused bits stay zero.
    always_comb begin
        if (!rst) begin
            assert_zero_bits_R1: assert (state_o[3] == 1'b0 && state_o[7:6] == 2'b00);
        end
    end

endmodule

bind engine_state_ctrl engine_state_ctrl_checker u_checker (
    .clk          (clk),
    .rst          (rst),
    .mode_we_i    (mode_we_i),
    .mode_req_i   (mode_req_i),
    .soft_reset_i (soft_reset_i),
    .core_ready_i (core_ready_i),
    .state_o      (state_o),
    .fifo_flush_o (fifo_flush_o)
);

// File: tb/engine_state_ctrl_bench.sv
`timescale 1ns/1ps
module engine_state_ctrl_bench;

    localparam int N = 3;
    localparam logic [11:0] OPR = 12'hFF0;
    localparam logic [23:0] STR = 24'hFFFFFC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_we_i = 1'b0;
    logic [1:0]  mode_req_i = 2'd0;
    logic        soft_reset_i = 1'b0;
    logic        core_ready_i = 1'b0;
    logic [11:0] op_set_i = '0;
    logic [23:0] stat_set_i = '0;
    logic [7:0]  state_o;
    logic [11:0] op_flags_o;
    logic [23:0] serial_stat_o;
    logic        fifo_flush_o;

    always #2.5 clk = ~clk;

    engine_state_ctrl #(.XFER_CYCLES(N)) u_engine_state_ctrl (
        .clk           (clk),
        .rst           (rst),
        .mode_we_i     (mode_we_i),
        .mode_req_i    (mode_req_i),
        .soft_reset_i  (soft_reset_i),
        .core_ready_i  (core_ready_i),
        .op_set_i      (op_set_i),
        .stat_set_i    (stat_set_i),
        .state_o       (state_o),
        .op_flags_o    (op_flags_o),
        .serial_stat_o (serial_stat_o),
        .fifo_flush_o  (fifo_flush_o)
    );

    typedef struct {
        logic [7:0]  st;
        logic [11:0] op;
        logic [23:0] stat;
        logic        flush;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    // Requirement-level model
    logic [1:0]  m_mode = 0, m_pend = 0;
    int          m_cnt = 0;
    logic        m_err = 0, m_mr = 0, m_fl = 0;
    logic [11:0] m_op = OPR;
    logic [23:0] m_stat = STR;
    logic        cr_hold = 0;

    function automatic bit move_ok(logic [1:0] from, logic [1:0] to);
        return (to == 2'd0) || (to == 2'd1) || (to == 2'd3 && from == 2'd1);
    endfunction

    task automatic step(input logic wr, input logic [1:0] rq, input logic sw,
                        input logic [11:0] os, input logic [23:0] ss, input string tag);
        exp_t e;
        @(negedge clk);
        mode_we_i = wr; mode_req_i = rq; soft_reset_i = sw;
        core_ready_i = cr_hold; op_set_i = os; stat_set_i = ss;
        m_mr = cr_hold;
        m_fl = sw;
        if (sw) begin
            m_mode = 0; m_pend = 0; m_cnt = 0; m_err = 0; m_op = OPR; m_stat = STR;
        end else begin
            if (m_cnt != 0) begin
                m_cnt--;
                if (m_cnt == 0) m_mode = m_pend;
            end else if (wr) begin
                if (move_ok(m_mode, rq)) begin m_pend = rq; m_cnt = N; end
                else m_err = 1;
            end
            m_op = m_op | os;
            m_stat = m_stat | ss;
        end
        e.st = {2'b00, m_err, m_mr, 1'b0, (m_cnt == 0), m_mode};
        e.op = m_op; e.stat = m_stat; e.flush = m_fl; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(0, 2'd0, 0, '0, '0, tag);
    endtask

    task automatic req(input logic [1:0] rq, input string tag);
        step(1, rq, 0, '0, '0, tag);
    endtask

    // Monitor: compare one item per cycle just after the edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (state_o !== e.st || op_flags_o !== e.op ||
                serial_stat_o !== e.stat || fifo_flush_o !== e.flush) begin
                n_bad++;
                $display("FAIL %s: state=%h op=%h stat=%h flush=%b expected state=%h op=%h stat=%h flush=%b",
                         e.tag, state_o, op_flags_o, serial_stat_o, fifo_flush_o,
                         e.st, e.op, e.stat, e.flush);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        idle("R1 reset values");
        idle("R1 reset values hold");
        // R2: reset -> run with delay
        req(2'd1, "R2 accept run");
        for (int i = 0; i < N; i++) idle("R2 run pending/complete");
        // R3: write while busy ignored
        req(2'd0, "R3 accept reset");
        req(2'd1, "R3 write while busy");
        req(2'd3, "R3 write while busy");
        for (int i = 0; i < N; i++) idle("R3 outcome keeps first request");
        // R4: pause from reset is illegal, then run, then pause legal
        req(2'd3, "R4 pause from reset refused");
        idle("R5 error sticky");
        step(0, 2'd0, 1, '0, '0, "R6 soft reset clears error");
        idle("R7 flush low again");
        req(2'd1, "R4 run from reset");
        for (int i = 0; i < N; i++) idle("R2 run completes");
        req(2'd3, "R4 pause from run legal");
        for (int i = 0; i < N; i++) idle("R4 pause completes");
        // R5: pause from pause and code 2 illegal
        req(2'd3, "R5 pause from pause refused");
        req(2'd2, "R5 spare code refused");
        idle("R5 error stays");
        req(2'd1, "R4 run from pause legal");
        for (int i = 0; i < N; i++) idle("R5 error persists across change");
        // R6: soft reset in middle of pending change
        req(2'd0, "R6 accept reset request");
        idle("R6 pending");
        step(0, 2'd0, 1, '0, '0, "R6 soft reset aborts");
        idle("R7 flush strobe one cycle");
        idle("R6 stays reset");
        // R6: soft reset wins over write in same cycle
        step(1, 2'd1, 1, '0, '0, "R6 soft reset beats write");
        idle("R6 no transition started");
        // R8: master ready follows input
        cr_hold = 1;
        idle("R8 master ready rises");
        idle("R8 master ready held");
        cr_hold = 0;
        idle("R8 master ready falls");
        // R9: sticky flag and status collection
        step(0, 2'd0, 0, 12'h00F, 24'h000003, "R9 set low bits");
        step(0, 2'd0, 0, 12'h000, 24'h000000, "R9 bits sticky");
        step(0, 2'd0, 1, 12'h001, 24'h000001, "R9 soft reset reload wins");
        idle("R9 reload values");
        idle("R9 final");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule